// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This block forms a 64-bit memory effective address from operand fields that have already been decoded. The operand fields are a signed 32-bit displacement, an optional base register, an optional index register and a scale code. The unit holds its own bank of sixteen 64-bit general registers. It reads the base and the index from that bank and produces the sum one clock after a request strobe. It also raises an illegal-operand flag when the fields break the addressing rules.

A request can also be marked as an address-load. In that case the sum is not used to reach memory. It is written back into a destination register of the bank, and the written value is shown on a write-back port in the same cycle as the address. A separate write port loads the bank directly so that tests can preset it. Decoding, memory access, segmentation and condition flags are outside the block. Neither kind of request changes any flag.

Top module: `eaddr_unit`

## Requirements
- R1: After reset, `out_valid`, `out_illegal` and `wb_valid` are 0, `out_addr` is 0 and every register of the bank reads as 0.
- R2: One clock after `req_valid` is high, `out_valid` is 1 and `out_addr` equals sign-extended displacement + base term + (index term << `req_scale`), taken modulo 2^64.
- R3: When `req_base_en` is 0, the base term is zero and `req_base_sel` has no effect. When it is 1, any register, including register 4, may be the base.
- R4: When `req_idx_en` is 0, the index term is zero and `req_idx_sel` has no effect, even when it selects register 4.
- R5: Scale code values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R6: A present index that selects register 4 gives `out_illegal`=1 and `out_addr`=0, and no write-back is made.
- R7: An address-load (`req_load_addr`=1) with size code 2'b11 (64-bit) writes the full sum into register `req_dst_sel`. In the same cycle as the address, it shows `wb_valid`=1, `wb_sel`=destination and `wb_data`=value written. A request in the next cycle reads the new value.
- R8: An address-load with size code 2'b10 (32-bit) writes the low 32 bits of the sum, zero-extended. `out_addr` still carries the full 64-bit sum.
- R9: An address-load with size code 2'b00 (8-bit) or 2'b01 (16-bit) gives `out_illegal`=1 and `out_addr`=0. It performs no write-back and leaves the destination register unchanged.
- R10: A request with `req_load_addr`=0 never writes back, whatever `req_dst_sel` holds.
- R11: A cycle without `req_valid` gives `out_valid`=0 and `wb_valid`=0 one clock later.
- R12: A test write (`tl_we`=1) stores `tl_data` into register `tl_sel`, and a request in the following cycle sees that value.
- R13: The displacement is two's-complement and is sign-extended before the addition. A carry out of bit 63 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_disp | input | 32 | Signed displacement |
| req_base_en | input | 1 | Base term present |
| req_base_sel | input | 4 | Base register number |
| req_idx_en | input | 1 | Index term present |
| req_idx_sel | input | 4 | Index register number |
| req_scale | input | 2 | Index shift amount 0..3 |
| req_load_addr | input | 1 | Address-load: write result to a register |
| req_size | input | 2 | Size code: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit |
| req_dst_sel | input | 4 | Destination register of an address-load |
| tl_we | input | 1 | Test write enable |
| tl_sel | input | 4 | Test write register number |
| tl_data | input | 64 | Test write data |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Effective address (0 when illegal) |
| out_illegal | output | 1 | Illegal operand combination |
| wb_valid | output | 1 | Address-load write-back performed |
| wb_sel | output | 4 | Register written |
| wb_data | output | 64 | Value written |

## Verification
The address path is exercised with these forms:
- a bare displacement, with register 4 selected but marked absent;
- a single base;
- displacement plus base;
- base plus index at every scale;
- displacement plus scaled index with no base;
- a sum that wraps past 2^64.

Together these separate a wrong term mask, a wrong shift and a missing sign extension.

Address-loads are run at all four size codes and read back as bases. This tells truncation apart from full-width write-back, and shows when a rejected load corrupts its destination. A back-to-back load-then-use pair and a test write followed at once by a request check the timing of bank updates.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;

    localparam int XLEN    = 64;
    localparam int DISP_W  = 32;
    localparam int NREG    = 16;
    localparam int RSEL_W  = $clog2(NREG);
    localparam int SCALE_W = 2;
    localparam logic [RSEL_W-1:0] SP_REG = RSEL_W'(4);

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } opsize_e;

    typedef struct packed {
        logic [DISP_W-1:0]  disp;
        logic               base_en;
        logic [RSEL_W-1:0]  base_sel;
        logic               idx_en;
        logic [RSEL_W-1:0]  idx_sel;
        logic [SCALE_W-1:0] scale;
        logic               ld;
        opsize_e            size;
        logic [RSEL_W-1:0]  dst;
    } ea_req_t;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [XLEN-1:0]   addr;
        logic              wb_en;
        logic [RSEL_W-1:0] wb_sel;
        logic [XLEN-1:0]   wb_data;
    } ea_res_t;

    function automatic logic [XLEN-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic load_size_ok(input opsize_e s);
        return (s == SZ_32) || (s == SZ_64);
    endfunction

    function automatic logic [XLEN-1:0] narrow_to_size(input logic [XLEN-1:0] v,
                                                       input opsize_e s);
        logic [XLEN-1:0] r;
        r = v;
        if (s == SZ_32) r = {{(XLEN-32){1'b0}}, v[31:0]};
        return r;
    endfunction

endpackage

// File: rtl/eaddr_regfile.sv
module eaddr_regfile #(
    parameter int NREG   = 16,
    parameter int XLEN   = 64,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] rd_a_sel,
    output logic [XLEN-1:0]  rd_a_data,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [XLEN-1:0]  rd_b_data,
    input  logic             tw_en,
    input  logic [SEL_W-1:0] tw_sel,
    input  logic [XLEN-1:0]  tw_data,
    input  logic             ww_en,
    input  logic [SEL_W-1:0] ww_sel,
    input  logic [XLEN-1:0]  ww_data
);

    logic [XLEN-1:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic hit_w, hit_t;
        assign hit_w = ww_en && (ww_sel == SEL_W'(g));
        assign hit_t = tw_en && (tw_sel == SEL_W'(g));
        always_ff @(posedge clk) begin
            if (rst)        bank[g] <= '0;
            else if (hit_w) bank[g] <= ww_data;   // write-back wins a collision
            else if (hit_t) bank[g] <= tw_data;
        end
    end

    assign rd_a_data = bank[rd_a_sel];
    assign rd_b_data = bank[rd_b_sel];

endmodule

// File: rtl/eaddr_check.sv
module eaddr_check
    import eaddr_pkg::*;
(
    input  ea_req_t req,
    output logic    bad_index,
    output logic    bad_size,
    output logic    illegal
);

    always_comb begin
        bad_index = req.idx_en && (req.idx_sel == SP_REG);
        bad_size  = req.ld && !load_size_ok(req.size);
        illegal   = bad_index || bad_size;
    end

endmodule

// File: rtl/eaddr_sum.sv
module eaddr_sum
    import eaddr_pkg::*;
#(
    parameter int SHIFT_MAX = 3
) (
    input  ea_req_t         req,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] idx_val,
    output logic [XLEN-1:0] sum,
    output logic [XLEN-1:0] wb_val
);

    localparam int NSHIFT = SHIFT_MAX + 1;

    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] idx_term;
    logic [XLEN-1:0] shifted [NSHIFT];

    for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
        assign shifted[s] = idx_val << s;
    end

    always_comb begin
        base_term = req.base_en ? base_val : '0;
        idx_term  = '0;
        if (req.idx_en) idx_term = shifted[req.scale];
        sum    = sext_disp(req.disp) + base_term + idx_term;
        wb_val = narrow_to_size(sum, req.size);
    end

endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
    import eaddr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [31:0]  req_disp,
    input  logic         req_base_en,
    input  logic [3:0]   req_base_sel,
    input  logic         req_idx_en,
    input  logic [3:0]   req_idx_sel,
    input  logic [1:0]   req_scale,
    input  logic         req_load_addr,
    input  logic [1:0]   req_size,
    input  logic [3:0]   req_dst_sel,
    input  logic         tl_we,
    input  logic [3:0]   tl_sel,
    input  logic [63:0]  tl_data,
    output logic         out_valid,
    output logic [63:0]  out_addr,
    output logic         out_illegal,
    output logic         wb_valid,
    output logic [3:0]   wb_sel,
    output logic [63:0]  wb_data
);

    ea_req_t         req;
    logic [XLEN-1:0] base_val, idx_val, sum, wb_val;
    logic            bad_index, bad_size, illegal;
    logic            do_wb;
    ea_res_t         res_d, res_q;

    always_comb begin
        req.disp     = req_disp;
        req.base_en  = req_base_en;
        req.base_sel = req_base_sel;
        req.idx_en   = req_idx_en;
        req.idx_sel  = req_idx_sel;
        req.scale    = req_scale;
        req.ld       = req_load_addr;
        req.size     = opsize_e'(req_size);
        req.dst      = req_dst_sel;
    end

    eaddr_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_a_sel  (req.base_sel),
        .rd_a_data (base_val),
        .rd_b_sel  (req.idx_sel),
        .rd_b_data (idx_val),
        .tw_en     (tl_we),
        .tw_sel    (tl_sel),
        .tw_data   (tl_data),
        .ww_en     (do_wb),
        .ww_sel    (req.dst),
        .ww_data   (wb_val)
    );

    eaddr_check u_chk_ops (
        .req       (req),
        .bad_index (bad_index),
        .bad_size  (bad_size),
        .illegal   (illegal)
    );

    eaddr_sum #(.SHIFT_MAX((1 << SCALE_W) - 1)) u_sum (
        .req      (req),
        .base_val (base_val),
        .idx_val  (idx_val),
        .sum      (sum),
        .wb_val   (wb_val)
    );

    assign do_wb = req_valid && req.ld && !illegal;

    always_comb begin
        res_d         = res_q;
        res_d.valid   = req_valid;
        res_d.wb_en   = do_wb;
        if (req_valid) begin
            res_d.illegal = illegal;
            res_d.addr    = illegal ? '0 : sum;
            res_d.wb_sel  = req.dst;
            res_d.wb_data = do_wb ? wb_val : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign out_addr    = res_q.addr;
    assign out_illegal = res_q.illegal;
    assign wb_valid    = res_q.wb_en;
    assign wb_sel      = res_q.wb_sel;
    assign wb_data     = res_q.wb_data;

endmodule

// File: rtl/eaddr_unit_chk.sv
module eaddr_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_idx_en,
    input logic [3:0]  req_idx_sel,
    input logic        req_load_addr,
    input logic [1:0]  req_size,
    input logic [3:0]  req_dst_sel,
    input logic        out_valid,
    input logic [63:0] out_addr,
    input logic        out_illegal,
    input logic        wb_valid,
    input logic [3:0]  wb_sel,
    input logic [63:0] wb_data
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && !wb_valid)); // R11

    AST_SP_INDEX: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_idx_en && req_idx_sel == 4'd4) |=> (out_illegal && !wb_valid)); // R6

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_addr == 64'd0)); // R6

    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_load_addr && !req_size[1]) |=> (out_illegal && !wb_valid)); // R9

    AST_PLAIN_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_load_addr) |=> !wb_valid); // R10

    AST_WB_DEST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_load_addr) |=> (!wb_valid || wb_sel == $past(req_dst_sel))); // R7

    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_load_addr && req_size == 2'b10) |=>
            (!wb_valid || wb_data[63:32] == 32'd0)); // R8

endmodule

bind eaddr_unit eaddr_unit_chk u_unit_chk (.*);

// File: tb/sim_eaddr_unit.sv
module sim_eaddr_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_base_en, req_idx_en, req_load_addr, tl_we;
    logic [31:0] req_disp;
    logic [3:0]  req_base_sel, req_idx_sel, req_dst_sel, tl_sel;
    logic [1:0]  req_scale, req_size;
    logic [63:0] tl_data;
    logic        out_valid, out_illegal, wb_valid;
    logic [63:0] out_addr, wb_data;
    logic [3:0]  wb_sel;

    eaddr_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [63:0] addr;
        logic        ill;
        logic        wbv;
        logic [3:0]  wbs;
        logic [63:0] wbd;
    } exp_t;

    exp_t        expq [$];
    string       tagq [$];
    logic [63:0] shadow [16];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R11 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check(out_addr == e.addr, {t, " addr"}, out_addr, e.addr);
                check(out_illegal == e.ill, {t, " illegal"}, 64'(out_illegal), 64'(e.ill));
                check(wb_valid == e.wbv, {t, " wb_valid"}, 64'(wb_valid), 64'(e.wbv));
                if (e.wbv) begin
                    check(wb_sel == e.wbs, {t, " wb_sel"}, 64'(wb_sel), 64'(e.wbs));
                    check(wb_data == e.wbd, {t, " wb_data"}, wb_data, e.wbd);
                end
            end
        end
    end

    task automatic do_req(input bit ben, input logic [3:0] bsel, input bit ien,
                          input logic [3:0] isel, input logic [1:0] sc,
                          input logic [31:0] disp, input bit ld, input logic [1:0] sz,
                          input logic [3:0] dst, input string tag);
        exp_t        e;
        logic [63:0] s;
        @(negedge clk);
        req_valid = 1'b1; req_base_en = ben; req_base_sel = bsel; req_idx_en = ien;
        req_idx_sel = isel; req_scale = sc; req_disp = disp; req_load_addr = ld;
        req_size = sz; req_dst_sel = dst; tl_we = 1'b0;
        s = {{32{disp[31]}}, disp} + (ben ? shadow[bsel] : 64'd0)
            + (ien ? (shadow[isel] << sc) : 64'd0);
        e.ill  = (ien && isel == 4'd4) || (ld && (sz == 2'b00 || sz == 2'b01));
        e.addr = e.ill ? 64'd0 : s;
        e.wbv  = ld && !e.ill;
        e.wbs  = dst;
        e.wbd  = (sz == 2'b10) ? {32'd0, s[31:0]} : s;
        if (e.wbv) shadow[dst] = e.wbd;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; tl_we = 1'b0;
    endtask

    task automatic tload(input logic [3:0] r, input logic [63:0] v);
        @(negedge clk);
        req_valid = 1'b0; tl_we = 1'b1; tl_sel = r; tl_data = v;
        shadow[r] = v;
    endtask

    // read a register through a plain base-only request
    task automatic peek(input logic [3:0] r, input string tag);
        do_req(1'b1, r, 1'b0, 4'd0, 2'd0, 32'd0, 1'b0, 2'b11, 4'd0, tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                check(1'b0, "watchdog expired", 64'(cyc), 64'(WATCHDOG));
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = 64'd0;
        rst = 1'b1; req_valid = 1'b0; req_base_en = 1'b0; req_idx_en = 1'b0;
        req_load_addr = 1'b0; tl_we = 1'b0; req_disp = '0; req_base_sel = '0;
        req_idx_sel = '0; req_dst_sel = '0; tl_sel = '0; req_scale = '0;
        req_size = '0; tl_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!out_valid && !out_illegal && !wb_valid, "R1 flags after reset",
              {61'd0, out_valid, out_illegal, wb_valid}, 64'd0);
        check(out_addr == 64'd0, "R1 address after reset", out_addr, 64'd0);
        peek(4'd9, "R1 register cleared");

        tload(4'd1, 64'h0000_0000_0000_1000);
        tload(4'd2, 64'h0000_0000_0000_0010);
        tload(4'd4, 64'h0000_0000_0000_7000);
        tload(4'd5, 64'hFFFF_FFFF_FFFF_FFF0);
        tload(4'd7, 64'h0000_0001_2345_6789);

        do_req(1'b0, 4'd9, 1'b0, 4'd4, 2'd3, 32'h40, 1'b0, 2'b11, 4'd0, "R3 R4 disp only");
        do_req(1'b1, 4'd1, 1'b0, 4'd0, 2'd0, 32'd0, 1'b0, 2'b11, 4'd0, "R2 base only");
        do_req(1'b1, 4'd1, 1'b0, 4'd0, 2'd0, 32'd24, 1'b0, 2'b11, 4'd0, "R2 disp+base");
        for (int s = 0; s < 4; s++)
            do_req(1'b1, 4'd1, 1'b1, 4'd2, 2'(s), 32'd0, 1'b0, 2'b11, 4'd0, "R5 scaled index");
        do_req(1'b0, 4'd1, 1'b1, 4'd2, 2'd3, 32'hFFFF_FFF8, 1'b0, 2'b11, 4'd0, "R13 negative disp no base");
        do_req(1'b1, 4'd5, 1'b0, 4'd0, 2'd0, 32'h20, 1'b0, 2'b11, 4'd0, "R13 wrap discarded");
        do_req(1'b1, 4'd4, 1'b1, 4'd2, 2'd1, 32'd4, 1'b0, 2'b11, 4'd0, "R3 sp as base");
        do_req(1'b1, 4'd1, 1'b1, 4'd4, 2'd0, 32'd8, 1'b0, 2'b11, 4'd0, "R6 sp as index");

        do_req(1'b1, 4'd1, 1'b1, 4'd2, 2'd2, 32'd24, 1'b1, 2'b11, 4'd3, "R7 load 64");
        peek(4'd3, "R7 load-then-use");
        do_req(1'b1, 4'd7, 1'b0, 4'd0, 2'd0, 32'h10, 1'b1, 2'b10, 4'd6, "R8 load 32");
        peek(4'd6, "R8 zero-extended value");
        do_req(1'b1, 4'd1, 1'b0, 4'd0, 2'd0, 32'd1, 1'b1, 2'b00, 4'd3, "R9 size 8");
        do_req(1'b1, 4'd1, 1'b0, 4'd0, 2'd0, 32'd2, 1'b1, 2'b01, 4'd3, "R9 size 16");
        do_req(1'b1, 4'd1, 1'b1, 4'd4, 2'd0, 32'd3, 1'b1, 2'b11, 4'd3, "R6 load sp index");
        peek(4'd3, "R9 destination unchanged");
        do_req(1'b1, 4'd2, 1'b0, 4'd0, 2'd0, 32'd5, 1'b0, 2'b11, 4'd1, "R10 plain request");
        peek(4'd1, "R10 dst field ignored");

        idle();
        @(negedge clk);
        check(!out_valid && !wb_valid, "R11 idle cycle", {62'd0, out_valid, wb_valid}, 64'd0);

        tload(4'd8, 64'h0000_00AB_0000_0000);
        peek(4'd8, "R12 test write visible");

        idle();
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R2 all results seen", 64'(expq.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule